// File: doc/BRIEF.md
# Five-Channel Timer Register Bank

This block is the bus-facing register file for a group of five timer channels. A 32-bit request port with separate read and write strobes reaches each channel's control word, initial-count word and live count word through word-aligned offsets inside a 4 KiB window. The counting engines sit outside the block. They take their control and initial-count words from this bank. They report their live count back into it, and they give a one-cycle pulse each time they reach zero.

A shared status word collects those zero events, one bit per channel. Software clears bits by writing ones. Each channel's interrupt line is high while its status bit and the interrupt-enable bit of its own control word are both set. A watchdog-control word is held at a fixed value and can only be read. Read data is registered and appears on the cycle after the read strobe.

Top module: `tmr_bank_regs`

## Requirements
- R1: Control words sit at byte offsets 0x00, 0x04, 0x20, 0x24 and 0x40 for channels 0 to 4. A write stores all 32 bits, which read back unchanged and drive that channel's slice of `ctrl_out`. During the write cycle, `ctrl_wr_stb` pulses for that channel only.
- R2: Initial-count words sit at 0x08, 0x0C, 0x28, 0x2C and 0x48 for channels 0 to 4. A write stores all 32 bits, which read back unchanged and appear on `icnt_out`. During the write cycle, `icnt_wr_stb` pulses for that channel only.
- R3: Live-count words sit at 0x10, 0x14, 0x30, 0x34 and 0x50. A read returns that channel's slice of `cur_cnt`. A write to them changes no register and raises no strobe.
- R4: A high `zero_pulse[i]` sets bit i of the status word at 0x18 on the next edge. Bits 31:5 of the status word read as zero.
- R5: Writing the status word clears each bit written as 1. Bits written as 0 keep their value.
- R6: If a zero pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq[i]` is high exactly when bit 29 of channel i's control word and status bit i are both 1. It follows changes to either bit in the cycle they take effect.
- R8: The watchdog-control word at 0x1C reads 0x00000400 after reset, and writes to it have no effect.
- R9: Offsets not listed above, and offsets with bits 1:0 not zero, read as 0. Writes to them change nothing.
- R10: After reset, control words read 0x00000005, initial counts and status read 0, and every `irq` line is low for as long as `rst_n` is low.
- R11: `rdata` takes the addressed value at the edge where `rd_en` is high. It keeps its value through cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cur_cnt | input | 160 | Live count of each channel, channel i at bits 32i+31:32i |
| zero_pulse | input | 5 | One-cycle zero-reached event per channel |
| ctrl_out | output | 160 | Stored control words, channel i at bits 32i+31:32i |
| icnt_out | output | 160 | Stored initial counts, channel i at bits 32i+31:32i |
| ctrl_wr_stb | output | 5 | Control-word write pulse per channel |
| icnt_wr_stb | output | 5 | Initial-count write pulse per channel |
| irq | output | 5 | Interrupt line per channel |

## Verification
A channel's zero event and a software clear of the status word can land on the same edge. The set-wins rule decides the outcome. The bench sets two status bits and then, in one cycle, writes a clear mask covering both while pulsing only one of them. It then reads the status word and expects the pulsed bit still set and the other one cleared. The same overlap is checked on the interrupt path: the enabled channel's line must stay high across that edge.

// File: rtl/tmr_bank_pkg.sv
// Package: shared constants and offset arithmetic for the timer register bank.
// Assumes byte addressing with 32-bit words; the channel layout is fixed.
package tmr_bank_pkg;

    localparam int NUM_CH     = 5;
    localparam int DW         = 32;
    localparam int WIN_BYTES  = 4096;
    localparam int AW         = $clog2(WIN_BYTES);
    localparam int IE_BIT     = 29;

    localparam logic [AW-1:0] OFF_STAT = AW'(12'h018);
    localparam logic [AW-1:0] OFF_WDOG = AW'(12'h01C);

    localparam logic [DW-1:0] CTRL_RST = 32'h0000_0005;
    localparam logic [DW-1:0] ICNT_RST = 32'h0000_0000;
    localparam logic [DW-1:0] WDOG_RST = 32'h0000_0400;

    typedef enum logic [1:0] {
        K_CTRL = 2'd0,
        K_ICNT = 2'd1,
        K_CCNT = 2'd2
    } reg_kind_e;

    // Per-kind displacement from a channel's base offset.
    function automatic int kind_disp(reg_kind_e k);
        case (k)
            K_CTRL:  return 0;
            K_ICNT:  return 8;
            default: return 16;
        endcase
    endfunction

    // Channels 0..3 come in pairs 0x20 apart; channel 4 starts at 0x40.
    function automatic logic [AW-1:0] reg_off(int ch, reg_kind_e k);
        int base;
        if (ch < 4) base = (ch / 2) * 32 + (ch % 2) * 4;
        else        base = 64;
        return AW'(base + kind_disp(k));
    endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
// Module: tmr_addr_decode
// Turns a byte offset into one-hot hit lines for every register of the bank.
// Assumes the offset is already confined to the window; a misaligned offset
// hits nothing, so it reads as zero and writes are dropped.
module tmr_addr_decode
    import tmr_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    output logic [NUM_CH-1:0] hit_ctrl,
    output logic [NUM_CH-1:0] hit_icnt,
    output logic [NUM_CH-1:0] hit_ccnt,
    output logic              hit_stat,
    output logic              hit_wdog
);

    logic aligned;

    // Word alignment gate for every hit line.
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Compare against the offsets computed for this channel.
        assign hit_ctrl[c] = aligned && (addr == reg_off(c, K_CTRL));
        assign hit_icnt[c] = aligned && (addr == reg_off(c, K_ICNT));
        assign hit_ccnt[c] = aligned && (addr == reg_off(c, K_CCNT));
    end

    // Shared registers.
    assign hit_stat = aligned && (addr == OFF_STAT);
    assign hit_wdog = aligned && (addr == OFF_WDOG);

    // No two registers may share an offset.
    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_ctrl, hit_icnt, hit_ccnt, hit_stat, hit_wdog})) else $error("decode overlap"); // R9

endmodule

// File: rtl/tmr_chan_regs.sv
// Module: tmr_chan_regs
// Control and initial-count storage for one channel, with write pulses to
// the counting engine. Assumes hit lines are already decoded and aligned.
module tmr_chan_regs
    import tmr_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          hit_ctrl,
    input  logic          hit_icnt,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] icnt_q,
    output logic          ctrl_stb,
    output logic          icnt_stb
);

    // Write pulses seen by the channel in the cycle of the write.
    assign ctrl_stb = wr_en && hit_ctrl;
    assign icnt_stb = wr_en && hit_icnt;

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= CTRL_RST;
        else if (ctrl_stb) ctrl_q <= wdata;
    end

    // Initial-count word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        icnt_q <= ICNT_RST;
        else if (icnt_stb) icnt_q <= wdata;
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctrl) |=> (ctrl_q == $past(wdata))) else $error("ctrl load"); // R1
    AST_ICNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_icnt) |=> (icnt_q == $past(wdata))) else $error("icnt load"); // R2
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_ctrl) |=> $stable(ctrl_q)) else $error("ctrl changed"); // R9

endmodule

// File: rtl/tmr_int_status.sv
// Module: tmr_int_status
// Shared zero-event status word with write-one-to-clear and per-channel
// interrupt gating. Assumes zero pulses last one cycle; a set beats a clear.
module tmr_int_status
    import tmr_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] zero_pulse,
    input  logic [NUM_CH-1:0] ie,
    output logic [NUM_CH-1:0] stat_q,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] stat_d;

    // Clear mask applies only on a status write.
    assign clr_vec = clr_en ? clr_mask : '0;

    // Next status: clear first, then the set overrides.
    assign stat_d = (stat_q & ~clr_vec) | zero_pulse;

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Interrupt lines forced low while reset is asserted.
    assign irq = rst_n ? (ie & stat_q) : '0;

    AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_pulse != '0) |=> ((stat_q & $past(zero_pulse)) == $past(zero_pulse))) else $error("set lost"); // R4
    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (zero_pulse == '0)) |=> ((stat_q & $past(clr_mask)) == '0)) else $error("clear failed"); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ((zero_pulse & clr_mask) != '0))
        |=> ((stat_q & $past(zero_pulse & clr_mask)) == $past(zero_pulse & clr_mask))) else $error("set lost to clear"); // R6

endmodule

// File: rtl/tmr_bank_regs.sv
// Module: tmr_bank_regs (top)
// Bus front end for five timer channels: decode, per-channel storage,
// shared status and a fixed watchdog word, with one-cycle registered reads.
// Assumes accesses are whole 32-bit words; counting lives outside.
module tmr_bank_regs
    import tmr_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [NUM_CH*DW-1:0] cur_cnt,
    input  logic [NUM_CH-1:0]    zero_pulse,
    output logic [NUM_CH*DW-1:0] ctrl_out,
    output logic [NUM_CH*DW-1:0] icnt_out,
    output logic [NUM_CH-1:0]    ctrl_wr_stb,
    output logic [NUM_CH-1:0]    icnt_wr_stb,
    output logic [NUM_CH-1:0]    irq
);

    logic [NUM_CH-1:0]         hit_ctrl, hit_icnt, hit_ccnt;
    logic                      hit_stat, hit_wdog, any_hit;
    logic [NUM_CH-1:0][DW-1:0] ctrl_arr, icnt_arr;
    logic [NUM_CH-1:0]         ie;
    logic [NUM_CH-1:0]         stat_q;
    logic [DW-1:0]             wdog_q;
    logic [DW-1:0]             rd_mux;

    tmr_addr_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .hit_ctrl (hit_ctrl),
        .hit_icnt (hit_icnt),
        .hit_ccnt (hit_ccnt),
        .hit_stat (hit_stat),
        .hit_wdog (hit_wdog)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tmr_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wdata    (wdata),
            .hit_ctrl (hit_ctrl[c]),
            .hit_icnt (hit_icnt[c]),
            .ctrl_q   (ctrl_arr[c]),
            .icnt_q   (icnt_arr[c]),
            .ctrl_stb (ctrl_wr_stb[c]),
            .icnt_stb (icnt_wr_stb[c])
        );
        // Flatten stored words and pick out each interrupt enable.
        assign ctrl_out[c*DW +: DW] = ctrl_arr[c];
        assign icnt_out[c*DW +: DW] = icnt_arr[c];
        assign ie[c]                = ctrl_arr[c][IE_BIT];
    end

    tmr_int_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en     (wr_en && hit_stat),
        .clr_mask   (wdata[NUM_CH-1:0]),
        .zero_pulse (zero_pulse),
        .ie         (ie),
        .stat_q     (stat_q),
        .irq        (irq)
    );

    // Watchdog word: reset value only, writes are never accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_q <= WDOG_RST;
        else        wdog_q <= wdog_q;
    end

    // Any mapped register selected.
    assign any_hit = (|hit_ctrl) || (|hit_icnt) || (|hit_ccnt) || hit_stat || hit_wdog;

    // Read selection as an OR of gated sources; unmapped yields zero.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_ctrl[c]) rd_mux |= ctrl_arr[c];
            if (hit_icnt[c]) rd_mux |= icnt_arr[c];
            if (hit_ccnt[c]) rd_mux |= cur_cnt[c*DW +: DW];
        end
        if (hit_stat) rd_mux |= {{(DW-NUM_CH){1'b0}}, stat_q};
        if (hit_wdog) rd_mux |= wdog_q;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |=> (rdata == '0)) else $error("unmapped read nonzero"); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)) else $error("rdata moved"); // R11
    AST_WDOG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_wdog) |=> (rdata == WDOG_RST)) else $error("wdog value"); // R8

endmodule

// File: tb/tb_tmr_bank_regs.sv
module tb_tmr_bank_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [11:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [159:0] cur_cnt;
    logic [4:0]   zero_pulse = '0;
    logic [159:0] ctrl_out, icnt_out;
    logic [4:0]   ctrl_wr_stb, icnt_wr_stb, irq;
    logic [4:0]   last_cstb, last_istb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    localparam logic [11:0] CTRL_A [5] = '{12'h000, 12'h004, 12'h020, 12'h024, 12'h040};
    localparam logic [11:0] ICNT_A [5] = '{12'h008, 12'h00C, 12'h028, 12'h02C, 12'h048};
    localparam logic [11:0] CCNT_A [5] = '{12'h010, 12'h014, 12'h030, 12'h034, 12'h050};

    tmr_bank_regs dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .cur_cnt     (cur_cnt),
        .zero_pulse  (zero_pulse),
        .ctrl_out    (ctrl_out),
        .icnt_out    (icnt_out),
        .ctrl_wr_stb (ctrl_wr_stb),
        .icnt_wr_stb (icnt_wr_stb),
        .irq         (irq)
    );

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 5; c++) cur_cnt[c*32 +: 32] = 32'hC000_0000 + 32'(c * 32'h111);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired, all requirements act=%0d exp<=20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        #1 last_cstb = ctrl_wr_stb; last_istb = icnt_wr_stb;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(logic [4:0] m);
        @(negedge clk);
        zero_pulse = m;
        @(negedge clk);
        zero_pulse = '0;
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        for (int c = 0; c < 5; c++) begin
            rd(CTRL_A[c], d); chk("R10 ctrl reset", d, 32'h5);
            rd(ICNT_A[c], d); chk("R10 icnt reset", d, 32'h0);
        end
        rd(12'h018, d); chk("R10 status reset", d, 32'h0);
        chk("R10 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_ctrl_map();
        logic [31:0] d;
        for (int c = 0; c < 5; c++) begin
            wr(CTRL_A[c], 32'h1100_0A00 + 32'(c));
            chk("R1 ctrl strobe", 32'(last_cstb), 32'(5'b1 << c));
            chk("R1 ctrl_out", ctrl_out[c*32 +: 32], 32'h1100_0A00 + 32'(c));
        end
        for (int c = 0; c < 5; c++) begin
            rd(CTRL_A[c], d); chk("R1 ctrl readback", d, 32'h1100_0A00 + 32'(c));
        end
    endtask

    task automatic t_icnt_map();
        logic [31:0] d;
        for (int c = 0; c < 5; c++) begin
            wr(ICNT_A[c], 32'hA5A5_0000 + 32'(c * 7));
            chk("R2 icnt strobe", 32'(last_istb), 32'(5'b1 << c));
            chk("R2 icnt_out", icnt_out[c*32 +: 32], 32'hA5A5_0000 + 32'(c * 7));
        end
        for (int c = 0; c < 5; c++) begin
            rd(ICNT_A[c], d); chk("R2 icnt readback", d, 32'hA5A5_0000 + 32'(c * 7));
        end
    endtask

    task automatic t_ccnt_ro();
        logic [31:0] d;
        for (int c = 0; c < 5; c++) begin
            rd(CCNT_A[c], d); chk("R3 live count read", d, 32'hC000_0000 + 32'(c * 32'h111));
        end
        wr(CCNT_A[4], 32'hFFFF_FFFF);
        chk("R3 no strobe on live count write", 32'({last_cstb, last_istb}), 32'h0);
        rd(CTRL_A[4], d); chk("R3 ctrl4 untouched", d, 32'h1100_0A04);
        rd(ICNT_A[4], d); chk("R3 icnt4 untouched", d, 32'hA5A5_001C);
    endtask

    task automatic t_status_w1c();
        logic [31:0] d;
        wr(12'h018, 32'hFFFF_FFFF);
        pulse(5'b10001);
        rd(12'h018, d); chk("R4 status set", d, 32'h11);
        pulse(5'b01110);
        rd(12'h018, d); chk("R4 status all set, upper zero", d, 32'h1F);
        wr(12'h018, 32'h0000_000A);
        rd(12'h018, d); chk("R5 w1c partial", d, 32'h15);
        wr(12'h018, 32'h0);
        rd(12'h018, d); chk("R5 zero write keeps", d, 32'h15);
        wr(12'h018, 32'h1F);
        rd(12'h018, d); chk("R5 full clear", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(CTRL_A[2], 32'h2000_0000);
        pulse(5'b00110);
        chk("R7 irq2 before overlap", 32'(irq[2]), 32'h1);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h018; wdata = 32'h6; zero_pulse = 5'b00100;
        @(negedge clk);
        wr_en = 1'b0; zero_pulse = '0;
        chk("R6 irq2 stays across overlap", 32'(irq[2]), 32'h1);
        rd(12'h018, d); chk("R6 set wins over clear", d, 32'h4);
        wr(12'h018, 32'h4);
    endtask

    task automatic t_irq_gate();
        logic [31:0] d;
        wr(CTRL_A[3], 32'h0000_0000);
        pulse(5'b01000);
        chk("R7 status without enable", 32'(irq), 32'h0);
        wr(CTRL_A[3], 32'h2000_0000);
        chk("R7 enable raises", 32'(irq), 32'h08);
        wr(CTRL_A[3], 32'h0);
        chk("R7 disable lowers", 32'(irq), 32'h0);
        rd(12'h018, d); chk("R7 status kept when disabled", d, 32'h8);
        wr(CTRL_A[3], 32'h2000_0000);
        wr(12'h018, 32'h8);
        chk("R7 clear lowers", 32'(irq), 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] d;
        rd(12'h01C, d); chk("R8 wdog reset", d, 32'h400);
        wr(12'h01C, 32'h1234_5678);
        rd(12'h01C, d); chk("R8 wdog write ignored", d, 32'h400);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'h038, d); chk("R9 hole 0x38", d, 32'h0);
        rd(12'h044, d); chk("R9 hole 0x44", d, 32'h0);
        rd(12'hFFC, d); chk("R9 top of window", d, 32'h0);
        rd(12'h002, d); chk("R9 misaligned read", d, 32'h0);
        wr(12'h044, 32'hDEAD_BEEF);
        chk("R9 no strobe on hole", 32'({last_cstb, last_istb}), 32'h0);
        wr(12'h001, 32'hDEAD_BEEF);
        chk("R9 no strobe misaligned", 32'({last_cstb, last_istb}), 32'h0);
        rd(CTRL_A[0], d); chk("R9 ctrl0 untouched", d, 32'h1100_0A00);
        rd(ICNT_A[4], d); chk("R9 icnt4 untouched", d, 32'hA5A5_001C);
    endtask

    task automatic t_read_timing();
        logic [31:0] d;
        rd(CTRL_A[1], d);
        @(negedge clk);
        rd_en = 1'b1; addr = ICNT_A[1];
        #1 chk("R11 not before edge", rdata, 32'h1100_0A01);
        @(negedge clk);
        rd_en = 1'b0; addr = CTRL_A[2];
        chk("R11 one cycle later", rdata, 32'hA5A5_0007);
        @(negedge clk);
        @(negedge clk);
        chk("R11 held without strobe", rdata, 32'hA5A5_0007);
    endtask

    task automatic t_reset_irq();
        wr(CTRL_A[0], 32'h2000_0000);
        pulse(5'b00001);
        chk("R7 irq0 up", 32'(irq), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk("R10 irq low in reset", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R10 irq low held", 32'(irq), 32'h0);
        rst_n = 1'b1;
        chk("R10 ctrl0 reset", ctrl_out[31:0], 32'h5);
    endtask

    initial begin
        last_cstb = '0; last_istb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_wdog();
        t_ctrl_map();
        t_icnt_map();
        t_ccnt_ro();
        t_status_w1c();
        t_collision();
        t_irq_gate();
        t_unmapped();
        t_read_timing();
        t_reset_irq();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule